// File: doc/BRIEF.md
# Burst Column Address Sequencer

This block produces the column address of each beat of one memory burst. A start strobe captures a start column, a burst length code and an ordering select. From the next cycle the block presents the first column and then steps through the burst, one beat for each cycle in which the advance enable is high. Each beat stays inside the aligned window whose size is the burst length. The steps count upward in sequential order or follow the start column XOR the beat index in interleave order.

A full-row mode counts through every column of the row, wraps past the top back toward the start, and runs until it is stopped. A stop input ends a burst at once. A new start strobe replaces a running burst in the same cycle. Holding the advance enable low freezes the sequence at its current beat, which is how clock-suspend cycles are modelled.

Top module: `burst_col_seq`

## Requirements
- R1: After a synchronous active-low reset, `beat_valid_o`, `beat_last_o` and `cfg_err_o` are 0.
- R2: A cycle with `start_i` high gives, from the next cycle, `beat_valid_o` = 1 and `col_o` equal to the sampled `start_col_i` (beat 0). The length code and the order select are captured at the same time. Their later changes have no effect until the next start.
- R3: Length codes: 3'b000 = 1 beat, 3'b001 = 2, 3'b010 = 4, 3'b011 = 8, 3'b111 = full row. With `order_ilv_i` = 0 (sequential), beat i of a fixed burst of length BL is (S & ~(BL-1)) | ((S + i) & (BL-1)), where S is the start column.
- R4: With `order_ilv_i` = 1 (interleave), beat i of a fixed burst is S ^ i. For example, BL 8 starting at 5 gives 5,4,7,6,1,0,3,2.
- R5: `beat_last_o` is high exactly on beat BL-1 of a fixed-length burst. An advance on that beat drops `beat_valid_o` in the next cycle.
- R6: In full-row mode (code 3'b111 with sequential order), beat i is (S + i) mod 2^COL_W. `beat_last_o` stays 0 and the burst continues until it is stopped.
- R7: The codes 3'b100, 3'b101 and 3'b110, and code 3'b111 with interleave order, act as a 1-beat burst and set `cfg_err_o`. The flag stays set until reset.
- R8: While a burst is valid and `adv_i` is low, with no start or stop, `col_o` and `beat_valid_o` hold their values.
- R9: `stop_i` high without `start_i` clears `beat_valid_o` in the next cycle.
- R10: When `start_i` and `stop_i` are both high, or `start_i` arrives mid-burst, the new burst is loaded as in R2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | Load a new burst |
| start_col_i | input | COL_W | Start column |
| len_code_i | input | 3 | Burst length code |
| order_ilv_i | input | 1 | 0 sequential, 1 interleave |
| adv_i | input | 1 | Advance one beat |
| stop_i | input | 1 | End the current burst |
| col_o | output | COL_W | Column of the current beat |
| beat_valid_o | output | 1 | A burst beat is present |
| beat_last_o | output | 1 | Final beat of a fixed burst |
| cfg_err_o | output | 1 | Sticky reserved-setting flag |

## Verification
The assertions assume that every control input is a clean 0 or 1 at each edge, and that a start is the only way a burst begins. The properties on stop and start therefore need nothing about what happens between bursts. The stimulus changes the inputs only on the falling edge. The sweep covers every start column with every fixed length and both orders, inserting one-cycle stalls. Further runs cover full-row wrap, mid-burst restart, a start and a stop in the same cycle, and each reserved setting.

// File: rtl/burst_col_seq_pkg.sv
// Package: shared constants for the burst column sequencer.
// Assumes the length code is 3 bits wide.
package burst_col_seq_pkg;
    localparam int LEN_W = 3;

    typedef enum logic [LEN_W-1:0] {
        BLEN_1    = 3'b000,
        BLEN_2    = 3'b001,
        BLEN_4    = 3'b010,
        BLEN_8    = 3'b011,
        BLEN_FULL = 3'b111
    } blen_code_e;
endpackage

// File: rtl/bcs_len_decode.sv
// Module: turns a length code and an order select into a window mask.
// Also flags a full-row burst and a reserved setting. Purely combinational.
// Assumes MAX_LOG < COL_W. A reserved setting yields a 1-beat window (mask 0).
module bcs_len_decode
    import burst_col_seq_pkg::*;
#(
    parameter int COL_W   = 8,
    parameter int MAX_LOG = 3
) (
    input  logic [LEN_W-1:0] len_code_i,
    input  logic             ilv_i,
    output logic [COL_W-1:0] mask_o,
    output logic             full_o,
    output logic             bad_o
);
    // Decode: fixed lengths set the low log2(BL) mask bits.
    always_comb begin
        mask_o = '0;
        full_o = 1'b0;
        bad_o  = 1'b0;
        if (len_code_i == BLEN_FULL) begin
            if (ilv_i) begin
                bad_o = 1'b1;
            end else begin
                mask_o = '1;
                full_o = 1'b1;
            end
        end else if (int'(len_code_i) <= MAX_LOG) begin
            for (int b = 0; b < COL_W; b++) begin
                mask_o[b] = (b < int'(len_code_i));
            end
        end else begin
            bad_o = 1'b1;
        end
    end
endmodule

// File: rtl/bcs_beat_ctr.sv
// Module: beat index counter and burst-valid state.
// A start loads index 0 and takes priority over a stop. A stop ends the burst.
// An advance steps the index, or closes a fixed burst on its last beat.
// The full-row index wraps naturally modulo 2^COL_W.
module bcs_beat_ctr #(
    parameter int COL_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             stop_i,
    input  logic             adv_i,
    input  logic [COL_W-1:0] mask_i,
    input  logic             full_i,
    output logic [COL_W-1:0] idx_o,
    output logic             valid_o,
    output logic             last_o
);
    logic [COL_W-1:0] idx_q;
    logic             valid_q;

    // Last beat: index reaches the window size minus one, never in full-row mode.
    assign last_o  = valid_q && !full_i && (idx_q == mask_i);
    assign idx_o   = idx_q;
    assign valid_o = valid_q;

    // State update: load, stop, advance or hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q   <= '0;
            valid_q <= 1'b0;
        end else if (start_i) begin
            idx_q   <= '0;
            valid_q <= 1'b1;
        end else if (stop_i) begin
            valid_q <= 1'b0;
        end else if (valid_q && adv_i) begin
            if (last_o) valid_q <= 1'b0;
            else        idx_q   <= idx_q + 1'b1;
        end
    end

    // R6: the full-row mode never flags a last beat.
    p_full_no_last_r6: assert property (@(posedge clk) disable iff (!rst_n)
        full_i |-> !last_o);
    // R5: an advance on the last beat ends the burst unless a start reloads it.
    p_end_after_last_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (last_o && adv_i && !start_i) |=> !valid_o);
    // R9: a stop without a start clears the burst.
    p_stop_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_i && !start_i) |=> !valid_o);
endmodule

// File: rtl/bcs_addr_gen.sv
// Module: forms the column from the start column, the beat index and the mask.
// Window bits come from the ordering: a sum for sequential, an XOR for interleave.
// Bits outside the window keep the start column. Purely combinational.
module bcs_addr_gen #(
    parameter int COL_W = 8
) (
    input  logic [COL_W-1:0] start_col_i,
    input  logic [COL_W-1:0] idx_i,
    input  logic [COL_W-1:0] mask_i,
    input  logic             ilv_i,
    output logic [COL_W-1:0] col_o
);
    logic [COL_W-1:0] seq_w;
    logic [COL_W-1:0] ilv_w;

    // Candidate orderings across the whole column.
    always_comb begin
        seq_w = start_col_i + idx_i;
        ilv_w = start_col_i ^ idx_i;
    end

    // Per bit: inside the window take the ordering, outside keep the start bit.
    for (genvar b = 0; b < COL_W; b++) begin : g_bit
        assign col_o[b] = mask_i[b] ? (ilv_i ? ilv_w[b] : seq_w[b]) : start_col_i[b];
    end
endmodule

// File: rtl/burst_col_seq.sv
// Module: top of the burst column sequencer.
// Captures the burst setting on start and steps one beat per advance.
// Raises a sticky error for reserved settings.
// Assumes the inputs are synchronous to clk. The reset is synchronous and active low.
module burst_col_seq
    import burst_col_seq_pkg::*;
#(
    parameter int COL_W   = 8,
    parameter int MAX_LOG = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [COL_W-1:0] start_col_i,
    input  logic [LEN_W-1:0] len_code_i,
    input  logic             order_ilv_i,
    input  logic             adv_i,
    input  logic             stop_i,
    output logic [COL_W-1:0] col_o,
    output logic             beat_valid_o,
    output logic             beat_last_o,
    output logic             cfg_err_o
);
    logic [COL_W-1:0] dec_mask;
    logic             dec_full;
    logic             dec_bad;
    logic [COL_W-1:0] start_q;
    logic [COL_W-1:0] mask_q;
    logic             ilv_q;
    logic             full_q;
    logic             err_q;
    logic [COL_W-1:0] idx_w;

    bcs_len_decode #(.COL_W(COL_W), .MAX_LOG(MAX_LOG)) dec_i (
        .len_code_i (len_code_i),
        .ilv_i      (order_ilv_i),
        .mask_o     (dec_mask),
        .full_o     (dec_full),
        .bad_o      (dec_bad)
    );

    // Capture the setting of a new burst; the error flag accumulates.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_q <= '0;
            mask_q  <= '0;
            ilv_q   <= 1'b0;
            full_q  <= 1'b0;
            err_q   <= 1'b0;
        end else if (start_i) begin
            start_q <= start_col_i;
            mask_q  <= dec_mask;
            ilv_q   <= order_ilv_i;
            full_q  <= dec_full;
            err_q   <= err_q | dec_bad;
        end
    end

    bcs_beat_ctr #(.COL_W(COL_W)) ctr_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start_i),
        .stop_i  (stop_i),
        .adv_i   (adv_i),
        .mask_i  (mask_q),
        .full_i  (full_q),
        .idx_o   (idx_w),
        .valid_o (beat_valid_o),
        .last_o  (beat_last_o)
    );

    bcs_addr_gen #(.COL_W(COL_W)) gen_i (
        .start_col_i (start_q),
        .idx_i       (idx_w),
        .mask_i      (mask_q),
        .ilv_i       (ilv_q),
        .col_o       (col_o)
    );

    assign cfg_err_o = err_q;

    // R2 / R10: a start presents its start column as beat 0 in the next cycle.
    p_start_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (beat_valid_o && col_o == $past(start_col_i)));
    // R8: with no advance, start or stop, the current beat holds.
    p_stall_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_valid_o && !adv_i && !start_i && !stop_i) |=> (beat_valid_o && $stable(col_o)));
    // R7: the error flag never clears outside reset.
    p_err_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err_o |=> cfg_err_o);
    // R5: a last beat is always a valid beat.
    p_last_valid_r5: assert property (@(posedge clk) disable iff (!rst_n)
        beat_last_o |-> beat_valid_o);
endmodule

// File: tb/burst_col_seq_tb_top.sv
// Bench: sweeps every start column, fixed length and order.
// Also runs full-row wrap, restarts, stops and reserved settings.
module burst_col_seq_tb_top;
    localparam int COL_W = 8;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start_i = 1'b0;
    logic [COL_W-1:0] start_col_i = '0;
    logic [2:0]       len_code_i = '0;
    logic             order_ilv_i = 1'b0;
    logic             adv_i = 1'b0;
    logic             stop_i = 1'b0;
    logic [COL_W-1:0] col_o;
    logic             beat_valid_o;
    logic             beat_last_o;
    logic             cfg_err_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    burst_col_seq #(.COL_W(COL_W), .MAX_LOG(3)) dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .start_col_i(start_col_i),
        .len_code_i(len_code_i), .order_ilv_i(order_ilv_i), .adv_i(adv_i),
        .stop_i(stop_i), .col_o(col_o), .beat_valid_o(beat_valid_o),
        .beat_last_o(beat_last_o), .cfg_err_o(cfg_err_o)
    );

    always #10 clk = ~clk;

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int exp_col(int s, int bl, bit ilv, int i);
        int m = bl - 1;
        if (ilv) return s ^ i;
        return (s & ~m & 255) | ((s + i) & m);
    endfunction

    task automatic launch(input int s, input int code, input bit ilv);
        start_i = 1'b1; start_col_i = s[7:0]; len_code_i = code[2:0]; order_ilv_i = ilv;
        @(negedge clk);
        start_i = 1'b0;
        // Change the setting inputs after capture: they must have no effect (R2).
        len_code_i = 3'b111; order_ilv_i = ~ilv; start_col_i = ~s[7:0];
    endtask

    // One fixed burst with a stall on beat 1, checked beat by beat.
    task automatic run_fixed(input int s, input int code, input bit ilv);
        int bl = 1 << code;
        launch(s, code, ilv);
        for (int i = 0; i < bl; i++) begin
            chk(ilv ? "R4 col" : "R3 col", col_o, exp_col(s, bl, ilv, i));
            chk("R5 last", beat_last_o, (i == bl - 1) ? 1 : 0);
            if (i == 1 && (s % 5) == 0) begin
                adv_i = 1'b0;
                @(negedge clk);
                chk("R8 hold col", col_o, exp_col(s, bl, ilv, i));
                chk("R8 hold valid", beat_valid_o, 1);
            end
            adv_i = 1'b1;
            @(negedge clk);
        end
        chk("R5 end", beat_valid_o, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 valid", beat_valid_o, 0);
        chk("R1 last", beat_last_o, 0);
        chk("R1 err", cfg_err_o, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R3 / R4 / R5 / R8: exhaustive sweep of start, length and order.
        for (int code = 0; code < 4; code++)
            for (int ilv = 0; ilv < 2; ilv++)
                for (int s = 0; s < 256; s++)
                    run_fixed(s, code, ilv[0]);
        chk("R7 no err yet", cfg_err_o, 0);

        // R6: full row wraps across all columns and never flags last.
        for (int k = 0; k < 2; k++) begin
            int s = (k == 0) ? 0 : 200;
            launch(s, 7, 1'b0);
            adv_i = 1'b1;
            for (int i = 0; i < 300; i++) begin
                chk("R6 col", col_o, (s + i) & 255);
                chk("R6 last", beat_last_o, 0);
                chk("R6 valid", beat_valid_o, 1);
                @(negedge clk);
            end
            stop_i = 1'b1;
            @(negedge clk);
            stop_i = 1'b0;
            chk("R9 stop full row", beat_valid_o, 0);
        end

        // R9: stop in the middle of a fixed burst.
        launch(16, 3, 1'b0);
        adv_i = 1'b1;
        @(negedge clk);
        chk("R9 pre", col_o, 17);
        stop_i = 1'b1;
        @(negedge clk);
        stop_i = 1'b0;
        chk("R9 stop", beat_valid_o, 0);

        // R10: restart mid-burst, and start together with stop.
        launch(3, 3, 1'b0);
        @(negedge clk);
        @(negedge clk);
        chk("R10 pre", col_o, 5);
        stop_i = 1'b1;
        launch(8'h46, 2, 1'b1);
        stop_i = 1'b0;
        chk("R10 reload col", col_o, 8'h46);
        chk("R10 reload valid", beat_valid_o, 1);
        for (int i = 1; i < 4; i++) begin
            @(negedge clk);
            chk("R10 ilv beat", col_o, 8'h46 ^ i);
        end
        chk("R10 last", beat_last_o, 1);
        @(negedge clk);
        chk("R10 end", beat_valid_o, 0);

        // R7: reserved settings act as one beat and set the sticky flag.
        for (int r = 0; r < 4; r++) begin
            int code = (r < 3) ? 4 + r : 7;
            adv_i = 1'b1;
            launch(8'h9B, code, (r == 3));
            chk("R7 col", col_o, 8'h9B);
            chk("R7 last", beat_last_o, 1);
            chk("R7 err", cfg_err_o, 1);
            @(negedge clk);
            chk("R7 one beat", beat_valid_o, 0);
            if (r == 0) begin
                launch(0, 1, 1'b0);
                chk("R7 sticky", cfg_err_o, 1);
                @(negedge clk);
                @(negedge clk);
            end
        end

        // R1: reset clears the sticky flag.
        rst_n = 1'b0;
        @(negedge clk);
        chk("R1 err cleared", cfg_err_o, 0);
        chk("R1 valid cleared", beat_valid_o, 0);
        rst_n = 1'b1;
        @(negedge clk);
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (150000) @(posedge clk);
                n_chk++;
                n_bad++;
                $display("FAIL watchdog actual=timeout expected=completion");
            end
        join_any
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule